// File: doc/BRIEF.md
# CAN Transmit Message Selector

This block sits between host-side message storage and a bit-level CAN protocol engine. It owns two stores of outgoing frames: a single urgent slot and a first-in first-out queue of ordinary frames. Each frame is four 32-bit words, written by the host one word per cycle on a dedicated write port for each store. The frame counts as stored only when its fourth word arrives.

When no frame is being served, the selector picks the urgent slot if it is occupied, otherwise the queue head. It then locks onto that frame and presents all four words, plus a decoded identifier, format bits and length code, to the protocol engine under a valid flag. The engine answers with a pulse: success, lost arbitration or error. Only success frees the entry and ends the lock. Any failure leaves the same frame on offer, and no newer frame, urgent or not, can displace it.

Configuration mode and bus-off both pause the offer without disturbing stored frames or the lock. Full and empty flags describe the queue. A frame that finds its store already full is thrown away and leaves a sticky overflow flag behind.

Top module: `can_tx_select`

## Requirements
- R1: After reset, `tx_valid` is 0, `fifo_empty` is 1, and `fifo_full`, `hp_busy`, `hp_ovf` and `fifo_ovf` are all 0.
- R2: A frame is written as four consecutive word writes in the order identifier word, length word, data bytes 0–3, data bytes 4–7. It joins its store only on the fourth word. After three words the queue still reports empty and nothing is offered.
- R3: When no frame is locked, the selector is not paused and the urgent slot is occupied, that slot is chosen even if the queue holds older frames. `tx_src_hp` is 1 for the urgent slot and 0 for the queue.
- R4: A lost-arbitration or error pulse while `tx_valid` is 1 keeps the same frame offered. A success pulse that arrives together with either failure pulse counts as a failure.
- R5: While a frame is locked, no other frame is selected, including one newly written to the urgent slot.
- R6: A success pulse while `tx_valid` is 1 frees the offered entry: the queue pops, or the urgent slot empties. `tx_valid` is 0 in the following cycle, and the next frame is then selected.
- R7: While `cfg_mode` or `bus_off` is 1, `tx_valid` is 0. Stored frames and the current lock are kept, and the same frame is offered again once both are 0.
- R8: The queue delivers frames in write order. `fifo_full` is 1 when DEPTH frames (default 4) are stored, `fifo_empty` is 1 when none are stored, and the two are never both 1.
- R9: A fourth word that arrives while its store is full (queue at DEPTH, or urgent slot occupied) discards the whole frame and sets `fifo_ovf` or `hp_ovf` respectively. Both flags stay 1 until reset.
- R10: The identifier word is decoded as `tx_ident = {w[10:0], w[30:13]}` and `tx_ide = w[12]`. `tx_rtr` equals `w[31]` when `w[12]` is 1, and `w[11]` otherwise. `tx_dlc` is bits 3:0 of the length word.
- R11: Success, lost-arbitration and error pulses are ignored while `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Controller in configuration mode; pauses the offer |
| bus_off | input | 1 | Controller in bus-off; pauses the offer |
| hp_wr_en | input | 1 | Word write strobe for the urgent slot |
| hp_wr_data | input | 32 | Word written to the urgent slot |
| fifo_wr_en | input | 1 | Word write strobe for the queue |
| fifo_wr_data | input | 32 | Word written to the queue |
| tx_done | input | 1 | Engine pulse: frame sent cleanly |
| tx_arb_lost | input | 1 | Engine pulse: arbitration lost |
| tx_err | input | 1 | Engine pulse: transmission error |
| tx_valid | output | 1 | A locked frame is offered to the engine |
| tx_src_hp | output | 1 | Offered frame comes from the urgent slot |
| tx_id_word | output | 32 | Identifier word of the offered frame |
| tx_len_word | output | 32 | Length word of the offered frame |
| tx_data_lo | output | 32 | Data bytes 0–3 |
| tx_data_hi | output | 32 | Data bytes 4–7 |
| tx_ident | output | 29 | Decoded identifier |
| tx_ide | output | 1 | Extended-format bit |
| tx_rtr | output | 1 | Remote-request bit for the frame's format |
| tx_dlc | output | 4 | Data length code |
| hp_busy | output | 1 | Urgent slot occupied |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| hp_ovf | output | 1 | Sticky: a frame for the urgent slot was dropped |
| fifo_ovf | output | 1 | Sticky: a frame for the queue was dropped |

## Verification
The properties assume the engine's answer pulses last one cycle and are only meaningful while a frame is on offer. The stability checks across a retry also rely on the host never reloading a store that is reported full. The bench holds each answer pulse for exactly one cycle, and it only writes words in groups of four, with no gaps inside a frame. It does issue pulses while paused or idle, and it writes to full stores on purpose, so that the ignore and drop paths are driven at the ports.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MSG_WORDS = 4;
    localparam int unsigned WCNT_W    = $clog2(MSG_WORDS);

    typedef logic [WORD_W-1:0] word_t;

    // Field order matters: identifier first, then length, then data words.
    typedef struct packed {
        word_t id;
        word_t len;
        word_t dlo;
        word_t dhi;
    } can_msg_t;

endpackage

// File: rtl/can_msg_assemble.sv
module can_msg_assemble
    import can_txsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  word_t    wr_data,
    input  logic     room,
    output logic     commit,
    output logic     reject,
    output can_msg_t msg
);

    typedef struct packed {
        logic [WCNT_W-1:0]                cnt;
        logic [MSG_WORDS-2:0][WORD_W-1:0] stage;
    } asm_state_t;

    asm_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        reject = 1'b0;
        if (wr_en) begin
            if (st_q.cnt == WCNT_W'(MSG_WORDS - 1)) begin
                commit   = room;
                reject   = !room;
                st_d.cnt = '0;
            end else begin
                st_d.stage[st_q.cnt] = wr_data;
                st_d.cnt             = st_q.cnt + WCNT_W'(1);
            end
        end
        msg.id  = st_q.stage[0];
        msg.len = st_q.stage[1];
        msg.dlo = st_q.stage[2];
        msg.dhi = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_tx_hpbuf.sv
module can_tx_hpbuf
    import can_txsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  can_msg_t load_msg,
    input  logic     free,
    output logic     full,
    output can_msg_t msg
);

    typedef struct packed {
        logic     full;
        can_msg_t msg;
    } hp_state_t;

    hp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (free) st_d.full = 1'b0;
        if (load && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.msg  = load_msg;
        end
        full = st_q.full;
        msg  = st_q.msg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_tx_fifo.sv
module can_tx_fifo
    import can_txsel_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  can_msg_t push_msg,
    input  logic     pop,
    output logic     full,
    output logic     empty,
    output can_msg_t head
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        can_msg_t [DEPTH-1:0] mem;
        logic [AW-1:0]        rd;
        logic [AW-1:0]        wr;
        logic [CW-1:0]        cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            st_d.mem[st_q.wr] = push_msg;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (pop_ok) st_d.rd = ptr_next(st_q.rd);
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        head     = st_q.mem[st_q.rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_tx_lock.sv
module can_tx_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic hp_full,
    input  logic fifo_empty,
    input  logic fb_done,
    input  logic fb_arb_lost,
    input  logic fb_err,
    output logic valid,
    output logic lock,
    output logic src_hp,
    output logic hp_free,
    output logic fifo_pop
);

    typedef struct packed {
        logic lock;
        logic src_hp;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic success;

    always_comb begin
        st_d     = st_q;
        hp_free  = 1'b0;
        fifo_pop = 1'b0;
        valid    = st_q.lock && !halt;
        // any failure indication overrides a concurrent success
        success  = valid && fb_done && !fb_arb_lost && !fb_err;
        if (success) begin
            st_d.lock = 1'b0;
            hp_free   = st_q.src_hp;
            fifo_pop  = !st_q.src_hp;
        end else if (!st_q.lock && !halt) begin
            if (hp_full) begin
                st_d.lock   = 1'b1;
                st_d.src_hp = 1'b1;
            end else if (!fifo_empty) begin
                st_d.lock   = 1'b1;
                st_d.src_hp = 1'b0;
            end
        end
        lock   = st_q.lock;
        src_hp = st_q.src_hp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_tx_select.sv
module can_tx_select
    import can_txsel_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_mode,
    input  logic        bus_off,
    input  logic        hp_wr_en,
    input  logic [31:0] hp_wr_data,
    input  logic        fifo_wr_en,
    input  logic [31:0] fifo_wr_data,
    input  logic        tx_done,
    input  logic        tx_arb_lost,
    input  logic        tx_err,
    output logic        tx_valid,
    output logic        tx_src_hp,
    output logic [31:0] tx_id_word,
    output logic [31:0] tx_len_word,
    output logic [31:0] tx_data_lo,
    output logic [31:0] tx_data_hi,
    output logic [28:0] tx_ident,
    output logic        tx_ide,
    output logic        tx_rtr,
    output logic [3:0]  tx_dlc,
    output logic        hp_busy,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic        hp_ovf,
    output logic        fifo_ovf
);

    typedef struct packed {
        logic hp_ovf;
        logic fifo_ovf;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    logic     hp_commit, hp_reject, fq_commit, fq_reject;
    can_msg_t hp_new, fq_new, hp_msg, fq_head, sel_msg;
    logic     hp_full, hp_free, fq_pop, sel_lock, sel_src_hp, halt;

    assign halt = cfg_mode || bus_off;

    can_msg_assemble i_asm_hp (
        .clk(clk), .rst_n(rst_n), .wr_en(hp_wr_en), .wr_data(hp_wr_data),
        .room(!hp_full), .commit(hp_commit), .reject(hp_reject), .msg(hp_new)
    );

    can_msg_assemble i_asm_fq (
        .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr_en), .wr_data(fifo_wr_data),
        .room(!fifo_full), .commit(fq_commit), .reject(fq_reject), .msg(fq_new)
    );

    can_tx_hpbuf i_hpbuf (
        .clk(clk), .rst_n(rst_n), .load(hp_commit), .load_msg(hp_new),
        .free(hp_free), .full(hp_full), .msg(hp_msg)
    );

    can_tx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(fq_commit), .push_msg(fq_new),
        .pop(fq_pop), .full(fifo_full), .empty(fifo_empty), .head(fq_head)
    );

    can_tx_lock i_lock (
        .clk(clk), .rst_n(rst_n), .halt(halt), .hp_full(hp_full),
        .fifo_empty(fifo_empty), .fb_done(tx_done), .fb_arb_lost(tx_arb_lost),
        .fb_err(tx_err), .valid(tx_valid), .lock(sel_lock), .src_hp(sel_src_hp),
        .hp_free(hp_free), .fifo_pop(fq_pop)
    );

    always_comb begin
        fl_d          = fl_q;
        fl_d.hp_ovf   = fl_q.hp_ovf   || hp_reject;
        fl_d.fifo_ovf = fl_q.fifo_ovf || fq_reject;

        sel_msg     = sel_src_hp ? hp_msg : fq_head;
        tx_src_hp   = sel_src_hp;
        tx_id_word  = sel_msg.id;
        tx_len_word = sel_msg.len;
        tx_data_lo  = sel_msg.dlo;
        tx_data_hi  = sel_msg.dhi;
        tx_ident    = {sel_msg.id[10:0], sel_msg.id[30:13]};
        tx_ide      = sel_msg.id[12];
        tx_rtr      = sel_msg.id[12] ? sel_msg.id[31] : sel_msg.id[11];
        tx_dlc      = sel_msg.len[3:0];
        hp_busy     = hp_full;
        hp_ovf      = fl_q.hp_ovf;
        fifo_ovf    = fl_q.fifo_ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

endmodule

// File: rtl/can_tx_select_chk.sv
module can_tx_select_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_mode,
    input logic        bus_off,
    input logic        tx_done,
    input logic        tx_arb_lost,
    input logic        tx_err,
    input logic        tx_valid,
    input logic        tx_src_hp,
    input logic [31:0] tx_id_word,
    input logic        hp_busy,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        hp_ovf,
    input logic        fifo_ovf,
    input logic        sel_lock
);

    a_r7_pause_blocks_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode || bus_off) |-> !tx_valid);

    a_r4_retry_same_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (tx_arb_lost || tx_err))
        |=> (sel_lock && $stable(tx_src_hp) && $stable(tx_id_word)));

    a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lock && !(tx_valid && tx_done))
        |=> (sel_lock && $stable(tx_src_hp)));

    a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lock && !cfg_mode && !bus_off && hp_busy) |=> (sel_lock && tx_src_hp));

    a_r6_success_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done && !tx_arb_lost && !tx_err) |=> !sel_lock);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r9_fifo_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> fifo_ovf);

    a_r9_hp_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hp_ovf |=> hp_ovf);

endmodule

bind can_tx_select can_tx_select_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .bus_off(bus_off),
    .tx_done(tx_done), .tx_arb_lost(tx_arb_lost), .tx_err(tx_err),
    .tx_valid(tx_valid), .tx_src_hp(tx_src_hp), .tx_id_word(tx_id_word),
    .hp_busy(hp_busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .hp_ovf(hp_ovf), .fifo_ovf(fifo_ovf), .sel_lock(sel_lock)
);

// File: tb/test_can_tx_select.sv
module test_can_tx_select;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    // {id_word, len_word, exp_ident, exp_ide, exp_rtr, exp_dlc}
    localparam int NVEC = 4;
    localparam logic [98:0] VEC [NVEC] = '{
        {32'h0000_0123, 32'h0000_0008, 29'h048C_0000, 1'b0, 1'b0, 4'h8},
        {32'h0000_0FFF, 32'h0000_0000, 29'h1FFC_0000, 1'b0, 1'b1, 4'h0},
        {32'h5555_5955, 32'hFFFF_FFF5, 29'h0556_AAAA, 1'b1, 1'b0, 4'h5},
        {32'hFFFF_F801, 32'h0000_000F, 29'h0007_FFFF, 1'b1, 1'b1, 4'hF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0, bus_off = 1'b0;
    logic        hp_wr_en = 1'b0, fifo_wr_en = 1'b0;
    logic [31:0] hp_wr_data = '0, fifo_wr_data = '0;
    logic        tx_done = 1'b0, tx_arb_lost = 1'b0, tx_err = 1'b0;
    logic        tx_valid, tx_src_hp, tx_ide, tx_rtr;
    logic [31:0] tx_id_word, tx_len_word, tx_data_lo, tx_data_hi;
    logic [28:0] tx_ident;
    logic [3:0]  tx_dlc;
    logic        hp_busy, fifo_full, fifo_empty, hp_ovf, fifo_ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_select #(.DEPTH(DEPTH)) i_can_tx_select (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_msg(input bit hp, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] w3,
                             input bit chk_partial);
        logic [31:0] w [4];
        w = '{w0, w1, w2, w3};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k == 3 && chk_partial) begin
                chk(fifo_empty == 1'b1, "R2", "empty after 3 words", 32'(fifo_empty), 32'd1);
                chk(tx_valid == 1'b0, "R2", "no offer after 3 words", 32'(tx_valid), 32'd0);
            end
            if (hp) begin hp_wr_en = 1'b1; hp_wr_data = w[k]; end
            else    begin fifo_wr_en = 1'b1; fifo_wr_data = w[k]; end
        end
        @(negedge clk);
        hp_wr_en = 1'b0;
        fifo_wr_en = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!tx_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(tx_valid == 1'b1, req, "offer appears", 32'(tx_valid), 32'd1);
    endtask

    task automatic pulse(input bit d, input bit a, input bit e);
        tx_done = d; tx_arb_lost = a; tx_err = e;
        @(negedge clk);
        tx_done = 1'b0; tx_arb_lost = 1'b0; tx_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_valid == 1'b0,   "R1", "tx_valid",   32'(tx_valid),   32'd0);
        chk(fifo_empty == 1'b1, "R1", "fifo_empty", 32'(fifo_empty), 32'd1);
        chk(fifo_full == 1'b0,  "R1", "fifo_full",  32'(fifo_full),  32'd0);
        chk(hp_busy == 1'b0,    "R1", "hp_busy",    32'(hp_busy),    32'd0);
        chk(hp_ovf == 1'b0 && fifo_ovf == 1'b0, "R1", "overflow flags",
            32'({hp_ovf, fifo_ovf}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: word order, commit on fourth word, identifier decode
        for (int i = 0; i < NVEC; i++) begin
            logic [98:0] v;
            v = VEC[i];
            write_msg(1'b0, v[98:67], v[66:35], 32'hD000_0000 + 32'(i),
                      32'hE000_0000 + 32'(i), 1'b1);
            chk(fifo_empty == 1'b0, "R2", "stored after word 4", 32'(fifo_empty), 32'd0);
            wait_valid("R2");
            chk(tx_id_word == v[98:67], "R2", "id word", tx_id_word, v[98:67]);
            chk(tx_len_word == v[66:35], "R2", "len word", tx_len_word, v[66:35]);
            chk(tx_data_lo == 32'hD000_0000 + 32'(i), "R2", "data lo", tx_data_lo,
                32'hD000_0000 + 32'(i));
            chk(tx_data_hi == 32'hE000_0000 + 32'(i), "R2", "data hi", tx_data_hi,
                32'hE000_0000 + 32'(i));
            chk(tx_ident == v[34:6], "R10", "ident", 32'(tx_ident), 32'(v[34:6]));
            chk(tx_ide == v[5], "R10", "ide", 32'(tx_ide), 32'(v[5]));
            chk(tx_rtr == v[4], "R10", "rtr", 32'(tx_rtr), 32'(v[4]));
            chk(tx_dlc == v[3:0], "R10", "dlc", 32'(tx_dlc), 32'(v[3:0]));
            pulse(1'b1, 1'b0, 1'b0);
            chk(tx_valid == 1'b0, "R6", "offer drops after success", 32'(tx_valid), 32'd0);
            chk(fifo_empty == 1'b1, "R6", "entry popped", 32'(fifo_empty), 32'd1);
        end

        // R8 / R9: fill the queue while paused, overflow, drain in order
        cfg_mode = 1'b1;
        for (int k = 0; k < DEPTH; k++)
            write_msg(1'b0, 32'h0000_0100 + 32'(k), 32'h8, 32'hA0 + 32'(k), 32'h0, 1'b0);
        chk(fifo_full == 1'b1, "R8", "full at depth", 32'(fifo_full), 32'd1);
        chk(tx_valid == 1'b0, "R7", "paused by cfg_mode", 32'(tx_valid), 32'd0);
        write_msg(1'b0, 32'h0000_0777, 32'h8, 32'hAF, 32'h0, 1'b0);
        chk(fifo_ovf == 1'b1, "R9", "queue overflow flag", 32'(fifo_ovf), 32'd1);
        chk(fifo_full == 1'b1, "R9", "still full", 32'(fifo_full), 32'd1);
        @(negedge clk);
        cfg_mode = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            wait_valid("R8");
            chk(tx_data_lo == 32'hA0 + 32'(k), "R8", "queue order", tx_data_lo,
                32'hA0 + 32'(k));
            pulse(1'b1, 1'b0, 1'b0);
        end
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b0 && fifo_empty == 1'b1, "R9", "dropped frame absent",
            32'({tx_valid, fifo_empty}), 32'd1);

        // R3: urgent slot beats older queue frame
        cfg_mode = 1'b1;
        write_msg(1'b0, 32'h0000_0200, 32'h1, 32'hB0, 32'h0, 1'b0);
        write_msg(1'b1, 32'h0000_0201, 32'h1, 32'hB1, 32'h0, 1'b0);
        chk(hp_busy == 1'b1, "R3", "urgent slot filled", 32'(hp_busy), 32'd1);
        @(negedge clk);
        cfg_mode = 1'b0;
        wait_valid("R3");
        chk(tx_src_hp == 1'b1 && tx_data_lo == 32'hB1, "R3", "urgent chosen first",
            tx_data_lo, 32'hB1);
        pulse(1'b1, 1'b0, 1'b0);
        wait_valid("R3");
        chk(tx_src_hp == 1'b0 && tx_data_lo == 32'hB0, "R3", "queue after urgent",
            tx_data_lo, 32'hB0);
        pulse(1'b1, 1'b0, 1'b0);

        // R4 / R5: retries and no preemption
        write_msg(1'b0, 32'h0000_0300, 32'h2, 32'hC0, 32'h0, 1'b0);
        wait_valid("R4");
        pulse(1'b0, 1'b1, 1'b0);
        chk(tx_valid == 1'b1 && tx_data_lo == 32'hC0, "R4", "retry after arb loss",
            tx_data_lo, 32'hC0);
        write_msg(1'b1, 32'h0000_0301, 32'h2, 32'hC1, 32'h0, 1'b0);
        chk(tx_src_hp == 1'b0 && tx_data_lo == 32'hC0, "R5", "no preemption",
            tx_data_lo, 32'hC0);
        pulse(1'b0, 1'b0, 1'b1);
        chk(tx_valid == 1'b1 && tx_data_lo == 32'hC0, "R4", "retry after error",
            tx_data_lo, 32'hC0);
        pulse(1'b1, 1'b0, 1'b1);
        chk(tx_valid == 1'b1 && tx_data_lo == 32'hC0, "R4", "failure beats success",
            tx_data_lo, 32'hC0);
        pulse(1'b1, 1'b0, 1'b0);
        wait_valid("R5");
        chk(tx_src_hp == 1'b1 && tx_data_lo == 32'hC1, "R5", "urgent after release",
            tx_data_lo, 32'hC1);
        write_msg(1'b1, 32'h0000_0302, 32'h2, 32'hC2, 32'h0, 1'b0);
        chk(hp_ovf == 1'b1, "R9", "urgent overflow flag", 32'(hp_ovf), 32'd1);
        chk(tx_data_lo == 32'hC1, "R9", "occupied slot unchanged", tx_data_lo, 32'hC1);
        pulse(1'b1, 1'b0, 1'b0);
        chk(hp_busy == 1'b0, "R6", "urgent slot freed", 32'(hp_busy), 32'd0);
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b0, "R9", "dropped urgent frame absent", 32'(tx_valid), 32'd0);

        // R7 / R11: pause keeps the lock; pulses while paused are ignored
        write_msg(1'b0, 32'h0000_0400, 32'h3, 32'hE0, 32'h0, 1'b0);
        wait_valid("R7");
        bus_off = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R7", "paused by bus_off", 32'(tx_valid), 32'd0);
        write_msg(1'b1, 32'h0000_0401, 32'h3, 32'hE1, 32'h0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        bus_off = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b1 && tx_src_hp == 1'b0 && tx_data_lo == 32'hE0, "R11",
            "pulse while paused ignored, lock kept", tx_data_lo, 32'hE0);
        pulse(1'b1, 1'b0, 1'b0);
        wait_valid("R7");
        chk(tx_src_hp == 1'b1 && tx_data_lo == 32'hE1, "R7", "urgent kept through pause",
            tx_data_lo, 32'hE1);
        pulse(1'b1, 1'b0, 1'b0);

        // R11: pulse with nothing stored
        pulse(1'b1, 1'b0, 1'b0);
        chk(fifo_empty == 1'b1 && hp_busy == 1'b0 && tx_valid == 1'b0, "R11",
            "idle pulse ignored", 32'({fifo_empty, hp_busy, tx_valid}), 32'h4);
        chk(hp_ovf == 1'b1 && fifo_ovf == 1'b1, "R9", "flags sticky",
            32'({hp_ovf, fifo_ovf}), 32'h3);

        finish_run();
    end

endmodule